// File: doc/BRIEF.md
# Clock Peripheral Indexed Register Port

This block is the register file that a host sees when it talks to a real-time-clock peripheral. The host reaches it through two port locations. A write to the index location picks one of 128 byte slots. The data location then reads or writes the picked slot. Most slots behave as plain storage. Four control and status slots follow their own rules: an update-busy flag the host cannot write, a mode register, an interrupt-flag register that clears itself when read, and a fixed validity register.

A separate time engine and a periodic generator sit next to this block. They raise status through single-cycle set inputs. The engine also copies fresh time bytes in through its own write port. When the host writes a time or date slot while the mode register's freeze bit is clear, the write is passed on to the engine so that it can reload its count. The interrupt line is high whenever any flag is pending.

Top module: `rtc_regport`

## Requirements
- R1: A write with `bus_sel_data`=0 loads the slot index with `bus_wdata[6:0]`, and bit 7 is dropped. A write or read with `bus_sel_data`=1 reaches the slot at that index. The index holds its value across accesses.
- R2: After reset, slot 0x0A reads 0x26, slot 0x0B reads 0x02, slot 0x0C reads 0x00 and slot 0x0D reads 0x80. `irq` and `tload_vld` are low.
- R3: Bit 7 of slot 0x0A is the busy flag, and the host cannot write it. A host write to 0x0A replaces bits 6:0 and leaves bit 7 as it was.
- R4: `busy_set` sets the busy flag only while bit 7 (freeze) of slot 0x0B is 0. `busy_clr` clears the flag. A host write to 0x0B with data bit 7 = 1 clears the flag.
- R5: Slot 0x0C holds three pending flags: bit 6 set by `set_per`, bit 5 set by `set_alm` and bit 4 set by `set_upd`. Its bit 7 reads as the OR of bits 6:4, and bits 3:0 read 0. `irq` is high, from the cycle after a set pulse, while any of bits 6:4 is 1.
- R6: A host read of slot 0x0C returns its current contents. At the end of that cycle the slot is cleared to 0x00, so `irq` is low in the next cycle.
- R7: A set pulse that arrives in the same cycle as a read of 0x0C is not lost. The read returns the old value, and the new bit stays pending afterwards.
- R8: Host writes to slots 0x0C and 0x0D have no effect on what those slots read back.
- R9: A host data write to a time slot (0x00, 0x02, 0x04, 0x06, 0x07, 0x08, 0x09) while freeze is 0 raises `tload_vld` in that same cycle, carrying the slot index and data. A write while freeze is 1, or a write to any other slot, leaves it low. The byte is stored in either case.
- R10: `eng_wr` writes `eng_dat` into the slot at `eng_idx`. If the host writes the same slot in the same cycle, the host's data is the one kept.
- R11: `cfg_a` shows slot 0x0A (busy flag included) and `cfg_b` shows slot 0x0B, so that neighbouring logic can read the mode bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel_data | input | 1 | 0 selects the index location, 1 selects the data location |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data (combinational; 0x00 at the index location) |
| busy_set | input | 1 | Time engine: update in progress |
| busy_clr | input | 1 | Time engine: update finished |
| set_per | input | 1 | Periodic generator flag pulse |
| set_alm | input | 1 | Alarm match flag pulse |
| set_upd | input | 1 | Update-ended flag pulse |
| eng_wr | input | 1 | Time engine byte write strobe |
| eng_idx | input | 7 | Time engine byte slot |
| eng_dat | input | 8 | Time engine byte data |
| tload_vld | output | 1 | Host wrote a time slot while not frozen |
| tload_idx | output | 7 | Slot of that write |
| tload_dat | output | 8 | Data of that write |
| irq | output | 1 | Interrupt request |
| cfg_a | output | 8 | Current slot 0x0A |
| cfg_b | output | 8 | Current slot 0x0B |

## Verification
Most faults in this block show up at `bus_rdata` on the first read of the slot involved. A busy flag that a host write changed shows up on the next read of 0x0A. A flag register that failed to clear shows up as `irq` staying high one cycle after the read. A lost set pulse shows up as a 0x00 on the following read of 0x0C instead of the pending bit. Forwarding errors show up at once, in the write cycle itself, on `tload_vld`. A wrong priority between the host and engine write ports shows up on the next read of that slot.

// File: rtl/rtc_regport_pkg.sv
package rtc_regport_pkg;
  localparam int SLOT_A = 10;
  localparam int SLOT_B = 11;
  localparam int SLOT_C = 12;
  localparam int SLOT_D = 13;
  localparam logic [7:0] D_VALUE = 8'h80;

  // time and date slots forwarded to the engine
  function automatic logic is_time_slot(input int s);
    return (s == 0) || (s == 2) || (s == 4) || (s == 6) ||
           (s == 7) || (s == 8) || (s == 9);
  endfunction

  function automatic logic is_ctl_slot(input int s);
    return (s >= SLOT_A) && (s <= SLOT_D);
  endfunction

  // pend = {periodic, alarm, update}; summary in bit 7
  function automatic logic [7:0] flags_view(input logic [2:0] pend);
    return {|pend, pend, 4'h0};
  endfunction
endpackage

// File: rtl/rtc_idx_latch.sv
module rtc_idx_latch #(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] nxt,
  output logic [IDX_W-1:0] idx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx <= '0;
    else if (load) idx <= nxt;
  end
endmodule

// File: rtl/rtc_mode_regs.sv
module rtc_mode_regs #(
  parameter logic [7:0] A_INIT = 8'h26,
  parameter logic [7:0] B_INIT = 8'h02
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_a,
  input  logic       wr_b,
  input  logic [7:0] wdata,
  input  logic       busy_set,
  input  logic       busy_clr,
  output logic [7:0] reg_a,
  output logic [7:0] reg_b,
  output logic       uip
);
  logic [6:0] a_low_q;
  logic       uip_q;
  logic [7:0] b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_low_q <= A_INIT[6:0];
      b_q     <= B_INIT;
    end else begin
      if (wr_a) a_low_q <= wdata[6:0];
      if (wr_b) b_q     <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   uip_q <= A_INIT[7];
    else if (wr_b && wdata[7])    uip_q <= 1'b0;
    else if (busy_clr)            uip_q <= 1'b0;
    else if (busy_set && !b_q[7]) uip_q <= 1'b1;
  end

  assign reg_a = {uip_q, a_low_q};
  assign reg_b = b_q;
  assign uip   = uip_q;
endmodule

// File: rtl/rtc_flag_reg.sv
module rtc_flag_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_clr,
  input  logic [2:0] sets,
  output logic [2:0] pend
);
  logic [2:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (rd_clr ? 3'b000 : pend_q) | sets;
  end

  assign pend = pend_q;
endmodule

// File: rtl/rtc_byte_store.sv
module rtc_byte_store #(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             h_we,
  input  logic [IDX_W-1:0] h_idx,
  input  logic [7:0]       h_dat,
  input  logic             e_we,
  input  logic [IDX_W-1:0] e_idx,
  input  logic [7:0]       e_dat,
  input  logic [IDX_W-1:0] r_idx,
  output logic [7:0]       r_dat
);
  localparam int DEPTH = 1 << IDX_W;
  logic [7:0] mem [DEPTH];

  // host write placed last so it wins on a shared slot
  always_ff @(posedge clk) begin
    if (e_we) mem[e_idx] <= e_dat;
    if (h_we) mem[h_idx] <= h_dat;
  end

  assign r_dat = mem[r_idx];
endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
  import rtc_regport_pkg::*;
#(
  parameter int         IDX_W  = 7,
  parameter logic [7:0] A_INIT = 8'h26,
  parameter logic [7:0] B_INIT = 8'h02
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel_data,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             busy_set,
  input  logic             busy_clr,
  input  logic             set_per,
  input  logic             set_alm,
  input  logic             set_upd,
  input  logic             eng_wr,
  input  logic [IDX_W-1:0] eng_idx,
  input  logic [7:0]       eng_dat,
  output logic             tload_vld,
  output logic [IDX_W-1:0] tload_idx,
  output logic [7:0]       tload_dat,
  output logic             irq,
  output logic [7:0]       cfg_a,
  output logic [7:0]       cfg_b
);
  logic [IDX_W-1:0] idx;
  int               slot;
  logic             data_wr, data_rd;
  logic             a_host_wr, b_host_wr, b_wr_set, c_rd_evt, store_wr;
  logic             set_any, uip;
  logic [2:0]       c_pend;
  logic [7:0]       reg_a, reg_b, store_q;

  assign slot      = int'(idx);
  assign data_wr   = bus_wr && bus_sel_data;
  assign data_rd   = bus_rd && bus_sel_data;
  assign a_host_wr = data_wr && (slot == SLOT_A);
  assign b_host_wr = data_wr && (slot == SLOT_B);
  assign b_wr_set  = b_host_wr && bus_wdata[7];
  assign c_rd_evt  = data_rd && (slot == SLOT_C);
  assign store_wr  = data_wr && !is_ctl_slot(slot);
  assign set_any   = set_per || set_alm || set_upd;

  rtc_idx_latch #(.IDX_W(IDX_W)) u_idx (
    .clk(clk), .rst_n(rst_n),
    .load(bus_wr && !bus_sel_data),
    .nxt(bus_wdata[IDX_W-1:0]),
    .idx(idx)
  );

  rtc_mode_regs #(.A_INIT(A_INIT), .B_INIT(B_INIT)) u_mode (
    .clk(clk), .rst_n(rst_n),
    .wr_a(a_host_wr), .wr_b(b_host_wr), .wdata(bus_wdata),
    .busy_set(busy_set), .busy_clr(busy_clr),
    .reg_a(reg_a), .reg_b(reg_b), .uip(uip)
  );

  rtc_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n),
    .rd_clr(c_rd_evt),
    .sets({set_per, set_alm, set_upd}),
    .pend(c_pend)
  );

  rtc_byte_store #(.IDX_W(IDX_W)) u_store (
    .clk(clk),
    .h_we(store_wr), .h_idx(idx), .h_dat(bus_wdata),
    .e_we(eng_wr), .e_idx(eng_idx), .e_dat(eng_dat),
    .r_idx(idx), .r_dat(store_q)
  );

  always_comb begin
    if (!bus_sel_data)        bus_rdata = 8'h00;
    else if (slot == SLOT_A)  bus_rdata = reg_a;
    else if (slot == SLOT_B)  bus_rdata = reg_b;
    else if (slot == SLOT_C)  bus_rdata = flags_view(c_pend);
    else if (slot == SLOT_D)  bus_rdata = D_VALUE;
    else                      bus_rdata = store_q;
  end

  assign tload_vld = data_wr && is_time_slot(slot) && !reg_b[7];
  assign tload_idx = idx;
  assign tload_dat = bus_wdata;
  assign irq       = |c_pend;
  assign cfg_a     = reg_a;
  assign cfg_b     = reg_b;
endmodule

// File: rtl/rtc_regport_chk.sv
module rtc_regport_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq,
  input logic       uip,
  input logic [2:0] c_pend,
  input logic       c_rd_evt,
  input logic       set_any,
  input logic       set_per,
  input logic       a_host_wr,
  input logic       b_wr_set,
  input logic       busy_set,
  input logic       busy_clr,
  input logic       tload_vld,
  input logic [7:0] cfg_b
);
  p_uip_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
    a_host_wr && !busy_set && !busy_clr |=> uip == $past(uip));

  p_setclr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    b_wr_set |=> !uip);

  p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_set && cfg_b[7] |=> !$rose(uip));

  p_irq_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(set_any));

  p_rdclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    c_rd_evt && !set_any |=> !irq);

  p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_per |=> c_pend[2]);

  p_fwd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tload_vld |-> !cfg_b[7]);
endmodule

bind rtc_regport rtc_regport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .uip(uip), .c_pend(c_pend),
  .c_rd_evt(c_rd_evt), .set_any(set_any), .set_per(set_per),
  .a_host_wr(a_host_wr), .b_wr_set(b_wr_set), .busy_set(busy_set),
  .busy_clr(busy_clr), .tload_vld(tload_vld), .cfg_b(cfg_b)
);

// File: tb/rtc_regport_tb.sv
module rtc_regport_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       busy_set = 0, busy_clr = 0, set_per = 0, set_alm = 0, set_upd = 0;
  logic       eng_wr = 0;
  logic [6:0] eng_idx = '0;
  logic [7:0] eng_dat = '0;
  logic       tload_vld, irq;
  logic [6:0] tload_idx;
  logic [7:0] tload_dat, cfg_a, cfg_b;
  int         errors = 0, checks = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  rtc_regport u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel_data(sel), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata), .busy_set(busy_set),
    .busy_clr(busy_clr), .set_per(set_per), .set_alm(set_alm),
    .set_upd(set_upd), .eng_wr(eng_wr), .eng_idx(eng_idx), .eng_dat(eng_dat),
    .tload_vld(tload_vld), .tload_idx(tload_idx), .tload_dat(tload_dat),
    .irq(irq), .cfg_a(cfg_a), .cfg_b(cfg_b)
  );

  // op 0: index write, 1: data write, 2: data read and compare
  localparam int NV = 27;
  localparam logic [9:0] VEC [NV] = '{
    {2'd0, 8'hA0}, {2'd1, 8'h5A}, {2'd2, 8'h5A},
    {2'd0, 8'h7F}, {2'd1, 8'hC3}, {2'd2, 8'hC3},
    {2'd0, 8'h20}, {2'd2, 8'h5A},
    {2'd0, 8'h0A}, {2'd2, 8'h26}, {2'd0, 8'h0B}, {2'd2, 8'h02},
    {2'd0, 8'h0C}, {2'd2, 8'h00}, {2'd0, 8'h0D}, {2'd2, 8'h80},
    {2'd0, 8'h0A}, {2'd1, 8'hA5}, {2'd2, 8'h25}, {2'd1, 8'h26}, {2'd2, 8'h26},
    {2'd0, 8'h0D}, {2'd1, 8'h00}, {2'd2, 8'h80},
    {2'd0, 8'h0C}, {2'd1, 8'hF0}, {2'd2, 8'h00}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idx_wr(input logic [7:0] v);
    sel = 0; wr = 1; wdata = v; step(); wr = 0;
  endtask

  task automatic dat_wr(input logic [7:0] v);
    sel = 1; wr = 1; wdata = v; step(); wr = 0;
  endtask

  task automatic dat_rd(input string tag, input logic [7:0] exp);
    sel = 1; rd = 1; #2; check(tag, rdata, exp); step(); rd = 0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(); step(); rst_n = 1; step();
    check("R2 irq at reset", {7'd0, irq}, 8'h00);
    check("R2 tload_vld at reset", {7'd0, tload_vld}, 8'h00);
    check("R11 cfg_a at reset", cfg_a, 8'h26);
    check("R11 cfg_b at reset", cfg_b, 8'h02);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][9:8])
        2'd0: idx_wr(VEC[i][7:0]);
        2'd1: dat_wr(VEC[i][7:0]);
        default: dat_rd($sformatf("R1 R2 R3 R8 vector %0d", i), VEC[i][7:0]);
      endcase
    end

    // R3 with the busy flag set
    busy_set = 1; step(); busy_set = 0;
    idx_wr(8'h0A); dat_rd("R4 busy_set sets flag", 8'hA6);
    dat_wr(8'h20); dat_rd("R3 busy flag kept on write", 8'hA0);
    check("R11 cfg_a mirrors", cfg_a, 8'hA0);
    busy_clr = 1; step(); busy_clr = 0;
    dat_rd("R4 busy_clr clears", 8'h20);
    // R4 freeze write clears busy, busy_set masked while frozen
    busy_set = 1; step(); busy_set = 0;
    idx_wr(8'h0B); dat_wr(8'h82);
    check("R11 cfg_b mirrors", cfg_b, 8'h82);
    idx_wr(8'h0A); dat_rd("R4 freeze write clears busy", 8'h20);
    busy_set = 1; step(); busy_set = 0;
    dat_rd("R4 busy_set ignored while frozen", 8'h20);

    // R9 forwarding while frozen: none, byte still stored
    idx_wr(8'h00); sel = 1; wr = 1; wdata = 8'h33; #2;
    check("R9 no forward while frozen", {7'd0, tload_vld}, 8'h00);
    step(); wr = 0;
    dat_rd("R9 byte stored while frozen", 8'h33);
    idx_wr(8'h0B); dat_wr(8'h02);
    idx_wr(8'h02); sel = 1; wr = 1; wdata = 8'h45; #2;
    check("R9 forward valid", {7'd0, tload_vld}, 8'h01);
    check("R9 forward index", {1'b0, tload_idx}, 8'h02);
    check("R9 forward data", tload_dat, 8'h45);
    step(); wr = 0;
    idx_wr(8'h03); sel = 1; wr = 1; wdata = 8'h12; #2;
    check("R9 alarm slot not forwarded", {7'd0, tload_vld}, 8'h00);
    step(); wr = 0;

    // R5 / R6 flag register
    set_alm = 1; step(); set_alm = 0;
    check("R5 irq after alarm pulse", {7'd0, irq}, 8'h01);
    idx_wr(8'h0C); dat_rd("R5 R6 read flags", 8'hA0);
    check("R6 irq low after read", {7'd0, irq}, 8'h00);
    dat_rd("R6 cleared after read", 8'h00);

    // R7 set pulse coincident with read
    set_upd = 1; step(); set_upd = 0;
    sel = 1; rd = 1; set_per = 1; #2;
    check("R7 read returns old value", rdata, 8'h90);
    step(); rd = 0; set_per = 0;
    check("R7 irq stays high", {7'd0, irq}, 8'h01);
    dat_rd("R7 new bit kept", 8'hC0);

    // R10 engine write and host priority
    eng_wr = 1; eng_idx = 7'h04; eng_dat = 8'h11; step(); eng_wr = 0;
    idx_wr(8'h04); dat_rd("R10 engine write", 8'h11);
    eng_wr = 1; eng_dat = 8'h33; sel = 1; wr = 1; wdata = 8'h22; step();
    eng_wr = 0; wr = 0;
    dat_rd("R10 host wins", 8'h22);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule